// File: doc/BRIEF.md
# Two-Port Byte-Lane Shared RAM

This block is a synchronous shared memory with two fully independent ports, called left and right. Each port can read or write any word, including the word the other port is using in the same cycle. Configured with 15 address bits, it holds 32768 words of 16 bits. The default parameter uses 11 address bits so that elaboration stays small. A word is split into an upper byte lane (bits 15:8) and a lower byte lane (bits 7:0). A write stores only the lanes that are selected. A read drives only the lanes that are selected.

Each port has a pair of chip enables of opposite polarity, a read/write strobe, an output enable, two lane selects and a semaphore select. All of these controls are sampled on the rising clock edge. The tri-state data bus is modelled as a read-data vector plus a 2-bit drive vector, one bit per lane. A drive bit of 0 means that lane is in high impedance. Read data and drive bits appear one clock after the edge that samples the read.

Top module: `twoport_lane_ram`

## Requirements
- R1: Any word written through either port is read back unchanged through either port, at every address from 0 to 2^ADDR_W-1.
- R2: A port is selected only when `*_en_n` is 0 and `*_en_p` is 1. Any other combination writes nothing, and the drive vector after that edge is 2'b00.
- R3: While `*_sem_n` is 0, the port makes no memory access: nothing is written, and the drive vector is 2'b00.
- R4: In a selected write (`*_rw`=0), bits 15:8 are stored only if `*_hi_n` is 0, and bits 7:0 are stored only if `*_lo_n` is 0. `*_oe_n` has no effect on the write.
- R5: After a write edge, the drive vector of that port is 2'b00.
- R6: In a selected read (`*_rw`=1, `*_oe_n`=0), the drive vector after the edge is {~hi_n, ~lo_n}: bit 1 is the upper lane and bit 0 is the lower lane. Each driven lane carries the stored byte.
- R7: With both lane selects at 1, a selected port neither writes nor drives any lane.
- R8: A selected read with `*_oe_n` at 1 gives a drive vector of 2'b00.
- R9: If both ports write the same lane of the same address in one cycle, the right port's byte is stored. Lanes written by only one of the two ports take that port's byte.
- R10: A read of an address in the same cycle as a write to that address returns the contents from before the write.
- R11: After reset, both drive vectors are 2'b00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock for both ports |
| rst_n | input | 1 | Active-low reset of the output registers |
| l_en_n | input | 1 | Left chip enable, active low |
| l_en_p | input | 1 | Left chip enable, active high |
| l_rw | input | 1 | Left read (1) or write (0) |
| l_oe_n | input | 1 | Left output enable, active low |
| l_hi_n | input | 1 | Left upper-lane select, active low |
| l_lo_n | input | 1 | Left lower-lane select, active low |
| l_sem_n | input | 1 | Left semaphore select, active low; blocks memory access |
| l_addr | input | ADDR_W | Left word address |
| l_wdata | input | 16 | Left write data |
| l_rdata | output | 16 | Left read data |
| l_drive | output | 2 | Left lane drive enables {upper, lower} |
| r_en_n | input | 1 | Right chip enable, active low |
| r_en_p | input | 1 | Right chip enable, active high |
| r_rw | input | 1 | Right read (1) or write (0) |
| r_oe_n | input | 1 | Right output enable, active low |
| r_hi_n | input | 1 | Right upper-lane select, active low |
| r_lo_n | input | 1 | Right lower-lane select, active low |
| r_sem_n | input | 1 | Right semaphore select, active low; blocks memory access |
| r_addr | input | ADDR_W | Right word address |
| r_wdata | input | 16 | Right write data |
| r_rdata | output | 16 | Right read data |
| r_drive | output | 2 | Right lane drive enables {upper, lower} |

## Verification
Two kinds of same-cycle overlap between the ports are tested. In the first, both ports write one address in the same cycle, once with full words and once with disjoint lanes; the stored word must show the right port winning only where the lanes overlap. In the second, one port reads an address while the other port writes it; the read must return the old word, and a read in the following cycle must return the new one. A byte-masked reference array predicts every read, and every control combination has its drive vector checked.

// File: rtl/tpl_pkg.sv
package tpl_pkg;

    localparam int LANES  = 2;
    localparam int LANE_W = 8;
    localparam int DATA_W = LANES * LANE_W;

    typedef struct packed {
        logic en_n;
        logic en_p;
        logic rw;
        logic oe_n;
        logic hi_n;
        logic lo_n;
        logic sem_n;
    } port_ctl_t;

    typedef struct packed {
        logic [LANES-1:0] wr_lane;
        logic [LANES-1:0] rd_lane;
    } port_cmd_t;

endpackage

// File: rtl/tpl_port_decode.sv
module tpl_port_decode
    import tpl_pkg::*;
(
    input  port_ctl_t ctl,
    output port_cmd_t cmd
);

    logic             selected;
    logic             mem_access;
    logic [LANES-1:0] lane_on;

    always_comb begin
        selected   = !ctl.en_n && ctl.en_p;
        mem_access = selected && ctl.sem_n;
        lane_on    = {!ctl.hi_n, !ctl.lo_n};
        cmd        = '0;
        if (mem_access) begin
            if (!ctl.rw) begin
                cmd.wr_lane = lane_on;
            end else if (!ctl.oe_n) begin
                cmd.rd_lane = lane_on;
            end
        end
    end

endmodule

// File: rtl/tpl_lane_bank.sv
module tpl_lane_bank #(
    parameter int ADDR_W = 11,
    parameter int LANE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              l_we,
    input  logic              l_re,
    input  logic [ADDR_W-1:0] l_addr,
    input  logic [LANE_W-1:0] l_din,
    output logic [LANE_W-1:0] l_dout,
    input  logic              r_we,
    input  logic              r_re,
    input  logic [ADDR_W-1:0] r_addr,
    input  logic [LANE_W-1:0] r_din,
    output logic [LANE_W-1:0] r_dout
);

    localparam int DEPTH = 1 << ADDR_W;

    typedef struct packed {
        logic [LANE_W-1:0] l_data;
        logic [LANE_W-1:0] r_data;
    } rd_state_t;

    logic [LANE_W-1:0] mem [DEPTH];
    rd_state_t         rd_d, rd_q;
    logic              l_we_eff;

    always_comb begin
        l_we_eff = l_we && !(r_we && (r_addr == l_addr));
        rd_d     = rd_q;
        if (l_re) rd_d.l_data = mem[l_addr];
        if (r_re) rd_d.r_data = mem[r_addr];
    end

    always_ff @(posedge clk) begin
        if (l_we_eff) mem[l_addr] <= l_din;
        if (r_we)     mem[r_addr] <= r_din;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rd_q <= '0;
        else        rd_q <= rd_d;
    end

    assign l_dout = rd_q.l_data;
    assign r_dout = rd_q.r_data;

    // R9: on a same-lane, same-address collision the right byte is stored
    a_r9_right_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (l_we && r_we && (l_addr == r_addr)) |=> (mem[$past(r_addr)] == $past(r_din)));

endmodule

// File: rtl/twoport_lane_ram.sv
module twoport_lane_ram
    import tpl_pkg::*;
#(
    parameter int ADDR_W = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              l_en_n,
    input  logic              l_en_p,
    input  logic              l_rw,
    input  logic              l_oe_n,
    input  logic              l_hi_n,
    input  logic              l_lo_n,
    input  logic              l_sem_n,
    input  logic [ADDR_W-1:0] l_addr,
    input  logic [15:0]       l_wdata,
    output logic [15:0]       l_rdata,
    output logic [1:0]        l_drive,
    input  logic              r_en_n,
    input  logic              r_en_p,
    input  logic              r_rw,
    input  logic              r_oe_n,
    input  logic              r_hi_n,
    input  logic              r_lo_n,
    input  logic              r_sem_n,
    input  logic [ADDR_W-1:0] r_addr,
    input  logic [15:0]       r_wdata,
    output logic [15:0]       r_rdata,
    output logic [1:0]        r_drive
);

    typedef struct packed {
        logic [LANES-1:0] l_drv;
        logic [LANES-1:0] r_drv;
    } drv_state_t;

    port_ctl_t  l_ctl, r_ctl;
    port_cmd_t  l_cmd, r_cmd;
    drv_state_t drv_d, drv_q;

    assign l_ctl = '{en_n: l_en_n, en_p: l_en_p, rw: l_rw, oe_n: l_oe_n,
                     hi_n: l_hi_n, lo_n: l_lo_n, sem_n: l_sem_n};
    assign r_ctl = '{en_n: r_en_n, en_p: r_en_p, rw: r_rw, oe_n: r_oe_n,
                     hi_n: r_hi_n, lo_n: r_lo_n, sem_n: r_sem_n};

    tpl_port_decode u_dec_l (.ctl(l_ctl), .cmd(l_cmd));
    tpl_port_decode u_dec_r (.ctl(r_ctl), .cmd(r_cmd));

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        tpl_lane_bank #(
            .ADDR_W (ADDR_W),
            .LANE_W (LANE_W)
        ) u_bank (
            .clk    (clk),
            .rst_n  (rst_n),
            .l_we   (l_cmd.wr_lane[g]),
            .l_re   (l_cmd.rd_lane[g]),
            .l_addr (l_addr),
            .l_din  (l_wdata[g*LANE_W +: LANE_W]),
            .l_dout (l_rdata[g*LANE_W +: LANE_W]),
            .r_we   (r_cmd.wr_lane[g]),
            .r_re   (r_cmd.rd_lane[g]),
            .r_addr (r_addr),
            .r_din  (r_wdata[g*LANE_W +: LANE_W]),
            .r_dout (r_rdata[g*LANE_W +: LANE_W])
        );
    end

    always_comb begin
        drv_d       = drv_q;
        drv_d.l_drv = l_cmd.rd_lane;
        drv_d.r_drv = r_cmd.rd_lane;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) drv_q <= '0;
        else        drv_q <= drv_d;
    end

    assign l_drive = drv_q.l_drv;
    assign r_drive = drv_q.r_drv;

    // R2: an unselected port drives nothing after the edge
    a_r2_deselect_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !(!l_en_n && l_en_p) |=> (l_drive == 2'b00));

    // R3: semaphore select low blocks the memory lanes
    a_r3_sem_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !r_sem_n |=> (r_drive == 2'b00));

    // R5: a write cycle leaves the port's lanes undriven
    a_r5_write_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !l_rw |=> (l_drive == 2'b00));

    // R6: a selected read with the upper lane picked drives that lane
    a_r6_upper_driven: assert property (@(posedge clk) disable iff (!rst_n)
        (!r_en_n && r_en_p && r_sem_n && r_rw && !r_oe_n && !r_hi_n) |=> r_drive[1]);

    // R8: output enable high keeps both lanes undriven
    a_r8_oe_high_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (r_rw && r_oe_n) |=> (r_drive == 2'b00));

endmodule

// File: tb/twoport_lane_ram_tb_top.sv
module twoport_lane_ram_tb_top;

    localparam int AW    = 11;
    localparam int DEPTH = 1 << AW;

    logic clk = 1'b0;
    logic rst_n;
    always #5 clk = ~clk;

    logic          l_en_n, l_en_p, l_rw, l_oe_n, l_hi_n, l_lo_n, l_sem_n;
    logic [AW-1:0] l_addr;
    logic [15:0]   l_wdata, l_rdata;
    logic [1:0]    l_drive;
    logic          r_en_n, r_en_p, r_rw, r_oe_n, r_hi_n, r_lo_n, r_sem_n;
    logic [AW-1:0] r_addr;
    logic [15:0]   r_wdata, r_rdata;
    logic [1:0]    r_drive;

    twoport_lane_ram #(.ADDR_W(AW)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .l_en_n(l_en_n), .l_en_p(l_en_p), .l_rw(l_rw), .l_oe_n(l_oe_n),
        .l_hi_n(l_hi_n), .l_lo_n(l_lo_n), .l_sem_n(l_sem_n),
        .l_addr(l_addr), .l_wdata(l_wdata), .l_rdata(l_rdata), .l_drive(l_drive),
        .r_en_n(r_en_n), .r_en_p(r_en_p), .r_rw(r_rw), .r_oe_n(r_oe_n),
        .r_hi_n(r_hi_n), .r_lo_n(r_lo_n), .r_sem_n(r_sem_n),
        .r_addr(r_addr), .r_wdata(r_wdata), .r_rdata(r_rdata), .r_drive(r_drive)
    );

    logic [15:0] ref_mem [DEPTH];
    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    task automatic chk(input string req, input logic [15:0] got, input logic [15:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, got, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic set_port(input bit right, input logic en_n, en_p, rw, oe_n, hi_n, lo_n, sem_n,
                            input logic [AW-1:0] a, input logic [15:0] d);
        if (right) begin
            r_en_n = en_n; r_en_p = en_p; r_rw = rw; r_oe_n = oe_n;
            r_hi_n = hi_n; r_lo_n = lo_n; r_sem_n = sem_n; r_addr = a; r_wdata = d;
        end else begin
            l_en_n = en_n; l_en_p = en_p; l_rw = rw; l_oe_n = oe_n;
            l_hi_n = hi_n; l_lo_n = lo_n; l_sem_n = sem_n; l_addr = a; l_wdata = d;
        end
    endtask

    task automatic idle_all();
        set_port(0, 1, 0, 1, 1, 1, 1, 1, '0, '0);
        set_port(1, 1, 0, 1, 1, 1, 1, 1, '0, '0);
    endtask

    function automatic void ref_put(input logic [AW-1:0] a, input logic [15:0] d,
                                    input logic hi_n, input logic lo_n);
        if (!hi_n) ref_mem[a][15:8] = d[15:8];
        if (!lo_n) ref_mem[a][7:0]  = d[7:0];
    endfunction

    function automatic logic [15:0] drv_of(input bit right);
        return right ? {14'd0, r_drive} : {14'd0, l_drive};
    endfunction

    task automatic wr(input bit right, input logic [AW-1:0] a, input logic [15:0] d,
                      input logic hi_n, input logic lo_n, input string req);
        set_port(right, 0, 1, 0, 1, hi_n, lo_n, 1, a, d);
        step();
        chk(req, drv_of(right), 16'd0);
        ref_put(a, d, hi_n, lo_n);
        idle_all();
    endtask

    task automatic rd(input bit right, input logic [AW-1:0] a,
                      input logic hi_n, input logic lo_n, input string req);
        logic [15:0] q;
        set_port(right, 0, 1, 1, 0, hi_n, lo_n, 1, a, '0);
        step();
        q = right ? r_rdata : l_rdata;
        chk(req, drv_of(right), {14'd0, !hi_n, !lo_n});
        if (!hi_n) chk(req, {8'd0, q[15:8]}, {8'd0, ref_mem[a][15:8]});
        if (!lo_n) chk(req, {8'd0, q[7:0]},  {8'd0, ref_mem[a][7:0]});
        idle_all();
    endtask

    task automatic t_reset();
        chk("R11 left drive", {14'd0, l_drive}, 16'd0);
        chk("R11 right drive", {14'd0, r_drive}, 16'd0);
    endtask

    task automatic t_full_words();
        logic [AW-1:0] addrs [4] = '{'0, 1, AW'(DEPTH-1), AW'(12'h2A5)};
        foreach (addrs[i]) begin
            wr(i[0], addrs[i], 16'hC3A0 ^ 16'(i * 16'h1111), 0, 0, "R5 write quiet");
            rd(!i[0], addrs[i], 0, 0, "R1 cross-port read");
            rd(i[0], addrs[i], 0, 0, "R6 same-port read");
        end
    endtask

    task automatic t_byte_write();
        wr(0, 11'h010, 16'h1234, 0, 0, "R5");
        wr(0, 11'h010, 16'hAB99, 0, 1, "R5");
        rd(1, 11'h010, 0, 0, "R4 upper only");
        wr(1, 11'h010, 16'h77CD, 1, 0, "R5");
        rd(0, 11'h010, 0, 0, "R4 lower only");
        set_port(0, 0, 1, 0, 0, 0, 0, 1, 11'h011, 16'h5A5A);
        step();
        chk("R5 write with oe low", {14'd0, l_drive}, 16'd0);
        ref_put(11'h011, 16'h5A5A, 0, 0);
        idle_all();
        rd(1, 11'h011, 0, 0, "R4 oe ignored on write");
    endtask

    task automatic t_deselect();
        logic [1:0] combos [3] = '{2'b11, 2'b00, 2'b10};
        foreach (combos[i]) begin
            set_port(0, combos[i][1], combos[i][0], 0, 1, 0, 0, 1, 11'h010, 16'hFFFF);
            step();
            chk("R2 deselected write drive", {14'd0, l_drive}, 16'd0);
            set_port(0, combos[i][1], combos[i][0], 1, 0, 0, 0, 1, 11'h010, 16'h0);
            step();
            chk("R2 deselected read drive", {14'd0, l_drive}, 16'd0);
            idle_all();
            rd(1, 11'h010, 0, 0, "R2 deselected write ignored");
        end
    endtask

    task automatic t_sem();
        set_port(1, 0, 1, 0, 1, 0, 0, 0, 11'h010, 16'h0F0F);
        step();
        chk("R3 sem write drive", {14'd0, r_drive}, 16'd0);
        set_port(1, 0, 1, 1, 0, 0, 0, 0, 11'h010, 16'h0);
        step();
        chk("R3 sem read drive", {14'd0, r_drive}, 16'd0);
        idle_all();
        rd(0, 11'h010, 0, 0, "R3 sem write ignored");
    endtask

    task automatic t_no_lanes();
        wr(0, 11'h010, 16'h1111, 1, 1, "R7 no-lane write drive");
        rd(0, 11'h010, 1, 1, "R7 no-lane read drive");
        rd(1, 11'h010, 0, 0, "R7 no-lane write ignored");
    endtask

    task automatic t_oe_high();
        set_port(0, 0, 1, 1, 1, 0, 0, 1, 11'h010, 16'h0);
        step();
        chk("R8 oe high", {14'd0, l_drive}, 16'd0);
        idle_all();
    endtask

    task automatic t_partial_read();
        rd(1, 11'h010, 0, 1, "R6 upper lane read");
        rd(0, 11'h011, 1, 0, "R6 lower lane read");
    endtask

    task automatic t_collision();
        set_port(0, 0, 1, 0, 1, 0, 0, 1, 11'h020, 16'h1111);
        set_port(1, 0, 1, 0, 1, 0, 0, 1, 11'h020, 16'h2222);
        step();
        ref_put(11'h020, 16'h2222, 0, 0);
        idle_all();
        rd(0, 11'h020, 0, 0, "R9 right wins");
        set_port(0, 0, 1, 0, 1, 0, 1, 1, 11'h020, 16'hAA00);
        set_port(1, 0, 1, 0, 1, 1, 0, 1, 11'h020, 16'h00BB);
        step();
        ref_put(11'h020, 16'hAABB, 0, 0);
        idle_all();
        rd(1, 11'h020, 0, 0, "R9 disjoint lanes merge");
    endtask

    task automatic t_read_during_write();
        wr(0, 11'h030, 16'h5555, 0, 0, "R5");
        set_port(0, 0, 1, 0, 1, 0, 0, 1, 11'h030, 16'h6666);
        set_port(1, 0, 1, 1, 0, 0, 0, 1, 11'h030, 16'h0);
        step();
        chk("R10 read during write drive", {14'd0, r_drive}, 16'h0003);
        chk("R10 read during write old data", r_rdata, 16'h5555);
        ref_put(11'h030, 16'h6666, 0, 0);
        idle_all();
        rd(1, 11'h030, 0, 0, "R10 new data next cycle");
    endtask

    initial begin
        idle_all();
        rst_n = 1'b0;
        repeat (3) step();
        rst_n = 1'b1;
        step();
        t_reset();
        t_full_words();
        t_byte_write();
        t_deselect();
        t_sem();
        t_no_lanes();
        t_oe_high();
        t_partial_read();
        t_collision();
        t_read_during_write();
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule